// File: doc/BRIEF.md
# Byte-Controlled Bidirectional Latched Transceiver

This block sits between two 16-bit buses, called side A and side B, and can move data in either direction. Each direction has a storage element of its own. The forward path captures from side A and presents the stored word to side B. The reverse path captures from side B and presents it to side A. The bus width is divided into bytes. Every byte has its own control set for each direction, so the bytes can run as separate 8-bit channels, or as one full-width channel when their controls are tied together.

Every direction of every byte has three active-low controls. A select gates everything else. A load input makes the store follow its source while it is low, and makes it keep its contents while it is high. A drive input turns the output on, but only while the select is also low. The tri-state pins are split into separate input, output-data and output-enable vectors, which keeps the block synthesizable. The stores are clocked registers: a store that is "transparent" reloads on every clock edge. If a byte is enabled to drive both directions at once, the block raises a per-byte contention flag.

All outputs are registered, so every result appears one clock edge after the inputs that cause it.

Top module: `byte_xcvr`

## Requirements
- R1: While synchronous reset `rst` is high, the next clock edge clears both stores of every byte and clears `a_out`, `b_out`, `a_oe`, `b_oe` and `clash` to zero.
- R2: When `a2b_sel_n[n]` and `a2b_load_n[n]` are both 0 at a clock edge, byte n of `b_out` (bits 8n+7..8n) takes the value of byte n of `a_in` after that edge.
- R3: When `a2b_sel_n[n]` is 0 and `a2b_load_n[n]` is 1 at an edge, byte n of `b_out` keeps its value, whatever `a_in` carries.
- R4: After an edge, all eight bits of byte n of `b_oe` are 1 if `a2b_sel_n[n]` and `a2b_drv_n[n]` were both 0 at that edge, and all eight are 0 otherwise. `a_oe` follows the same rule from `b2a_sel_n[n]` and `b2a_drv_n[n]`.
- R5: The reverse path mirrors R2 and R3. Byte n of `b_in` loads into byte n of `a_out` when `b2a_sel_n[n]` and `b2a_load_n[n]` are both 0, and the value holds otherwise.
- R6: The controls of byte n affect only bits 8n+7..8n of the outputs. The other byte keeps its stored data and its enables.
- R7: `clash[n]` is 1 after an edge exactly when both directions of byte n were enabled to drive at that edge (select and drive both 0 for A-to-B, and both 0 for B-to-A).
- R8: Data passes non-inverted. The output data bits always show the store contents, even while the matching enables are 0.
- R9: While a select is 1, a load value of 0 and a drive value of 0 on that byte and direction are ignored: the store holds and the enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 16 | Side A data sampled by the forward store |
| b_in | input | 16 | Side B data sampled by the reverse store |
| a2b_sel_n | input | 2 | Forward select per byte, active low |
| a2b_load_n | input | 2 | Forward load per byte, active low (low = follow, high = hold) |
| a2b_drv_n | input | 2 | Forward drive per byte, active low |
| b2a_sel_n | input | 2 | Reverse select per byte, active low |
| b2a_load_n | input | 2 | Reverse load per byte, active low |
| b2a_drv_n | input | 2 | Reverse drive per byte, active low |
| a_out | output | 16 | Reverse store contents presented to side A |
| a_oe | output | 16 | Per-bit enable for side A outputs |
| b_out | output | 16 | Forward store contents presented to side B |
| b_oe | output | 16 | Per-bit enable for side B outputs |
| clash | output | 2 | Per-byte flag: both directions driving |

## Verification
The bench builds the block with its defaults: a byte width of 8 and two bytes. Two bytes are the fewest that let one byte load, hold or drive while the other stays unchanged. They also let the contention flag be raised for one byte alone and then for both. With these sizes every bit pattern can be written out in hex, so each expected word is stated directly.

// File: rtl/byte_xcvr_pkg.sv
package byte_xcvr_pkg;
  // Control set for one direction of one byte (all active low).
  typedef struct packed {
    logic sel_n;
    logic load_n;
    logic drv_n;
  } dir_ctl_t;
endpackage

// File: rtl/xcvr_path.sv
module xcvr_path
  import byte_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  dir_ctl_t     ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         drive
);
  logic follow;
  logic enable_out;

  assign follow     = !ctl.sel_n && !ctl.load_n;
  assign enable_out = !ctl.sel_n && !ctl.drv_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      drive <= 1'b0;
    end else begin
      if (follow) q <= din;
      drive <= enable_out;
    end
  end
endmodule

// File: rtl/xcvr_slice.sv
module xcvr_slice
  import byte_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  dir_ctl_t     fwd_ctl,
  input  dir_ctl_t     rev_ctl,
  input  logic [W-1:0] a_d,
  input  logic [W-1:0] b_d,
  output logic [W-1:0] fwd_q,
  output logic [W-1:0] rev_q,
  output logic         fwd_drv,
  output logic         rev_drv,
  output logic         clash
);
  logic both_on;

  xcvr_path #(.W(W)) u_fwd (
    .clk(clk), .rst(rst), .ctl(fwd_ctl), .din(a_d), .q(fwd_q), .drive(fwd_drv)
  );

  xcvr_path #(.W(W)) u_rev (
    .clk(clk), .rst(rst), .ctl(rev_ctl), .din(b_d), .q(rev_q), .drive(rev_drv)
  );

  assign both_on = (!fwd_ctl.sel_n && !fwd_ctl.drv_n) &&
                   (!rev_ctl.sel_n && !rev_ctl.drv_n);

  always_ff @(posedge clk) begin
    if (rst) clash <= 1'b0;
    else     clash <= both_on;
  end
endmodule

// File: rtl/byte_xcvr.sv
module byte_xcvr
  import byte_xcvr_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2,
  localparam int DW       = BYTE_W * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DW-1:0]        a_in,
  input  logic [DW-1:0]        b_in,
  input  logic [NUM_BYTES-1:0] a2b_sel_n,
  input  logic [NUM_BYTES-1:0] a2b_load_n,
  input  logic [NUM_BYTES-1:0] a2b_drv_n,
  input  logic [NUM_BYTES-1:0] b2a_sel_n,
  input  logic [NUM_BYTES-1:0] b2a_load_n,
  input  logic [NUM_BYTES-1:0] b2a_drv_n,
  output logic [DW-1:0]        a_out,
  output logic [DW-1:0]        a_oe,
  output logic [DW-1:0]        b_out,
  output logic [DW-1:0]        b_oe,
  output logic [NUM_BYTES-1:0] clash
);
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    dir_ctl_t fwd_ctl, rev_ctl;
    logic     fwd_drv, rev_drv;
    logic [BYTE_W-1:0] fwd_q, rev_q;

    assign fwd_ctl = '{sel_n: a2b_sel_n[i], load_n: a2b_load_n[i], drv_n: a2b_drv_n[i]};
    assign rev_ctl = '{sel_n: b2a_sel_n[i], load_n: b2a_load_n[i], drv_n: b2a_drv_n[i]};

    xcvr_slice #(.W(BYTE_W)) u_slice (
      .clk(clk), .rst(rst),
      .fwd_ctl(fwd_ctl), .rev_ctl(rev_ctl),
      .a_d(a_in[i*BYTE_W +: BYTE_W]), .b_d(b_in[i*BYTE_W +: BYTE_W]),
      .fwd_q(fwd_q), .rev_q(rev_q),
      .fwd_drv(fwd_drv), .rev_drv(rev_drv),
      .clash(clash[i])
    );

    assign b_out[i*BYTE_W +: BYTE_W] = fwd_q;
    assign a_out[i*BYTE_W +: BYTE_W] = rev_q;
    assign b_oe[i*BYTE_W +: BYTE_W]  = {BYTE_W{fwd_drv}};
    assign a_oe[i*BYTE_W +: BYTE_W]  = {BYTE_W{rev_drv}};
  end
endmodule

// File: rtl/byte_xcvr_chk.sv
module byte_xcvr_chk #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2,
  localparam int DW       = BYTE_W * NUM_BYTES
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DW-1:0]        a_in,
  input logic [DW-1:0]        b_in,
  input logic [NUM_BYTES-1:0] a2b_sel_n,
  input logic [NUM_BYTES-1:0] a2b_load_n,
  input logic [NUM_BYTES-1:0] a2b_drv_n,
  input logic [NUM_BYTES-1:0] b2a_sel_n,
  input logic [NUM_BYTES-1:0] b2a_load_n,
  input logic [NUM_BYTES-1:0] b2a_drv_n,
  input logic [DW-1:0]        a_out,
  input logic [DW-1:0]        a_oe,
  input logic [DW-1:0]        b_out,
  input logic [DW-1:0]        b_oe,
  input logic [NUM_BYTES-1:0] clash
);
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (a_out == '0 && b_out == '0 && a_oe == '0 && b_oe == '0 && clash == '0));

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_chk
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
      (!a2b_sel_n[i] && !a2b_load_n[i]) |=>
        b_out[i*BYTE_W +: BYTE_W] == $past(a_in[i*BYTE_W +: BYTE_W]));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (a2b_sel_n[i] || a2b_load_n[i]) |=> $stable(b_out[i*BYTE_W +: BYTE_W]));

    p_oe_on_r4: assert property (@(posedge clk) disable iff (rst)
      (!a2b_sel_n[i] && !a2b_drv_n[i]) |=> (&b_oe[i*BYTE_W +: BYTE_W]));

    p_oe_off_r9: assert property (@(posedge clk) disable iff (rst)
      (a2b_sel_n[i] || a2b_drv_n[i]) |=> (b_oe[i*BYTE_W +: BYTE_W] == '0));

    p_rev_load_r5: assert property (@(posedge clk) disable iff (rst)
      (!b2a_sel_n[i] && !b2a_load_n[i]) |=>
        a_out[i*BYTE_W +: BYTE_W] == $past(b_in[i*BYTE_W +: BYTE_W]));

    p_rev_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (b2a_sel_n[i] || b2a_load_n[i]) |=> $stable(a_out[i*BYTE_W +: BYTE_W]));

    p_clash_set_r7: assert property (@(posedge clk) disable iff (rst)
      (!a2b_sel_n[i] && !a2b_drv_n[i] && !b2a_sel_n[i] && !b2a_drv_n[i]) |=> clash[i]);

    p_clash_clr_r7: assert property (@(posedge clk) disable iff (rst)
      (a2b_sel_n[i] || a2b_drv_n[i] || b2a_sel_n[i] || b2a_drv_n[i]) |=> !clash[i]);
  end
endmodule

bind byte_xcvr byte_xcvr_chk #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_chk (.*);

// File: tb/tb_byte_xcvr.sv
module tb_byte_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;
  localparam int NB = 2;
  localparam int DW = BW * NB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] a_in = '0, b_in = '0;
  logic [NB-1:0] a2b_sel_n = '1, a2b_load_n = '1, a2b_drv_n = '1;
  logic [NB-1:0] b2a_sel_n = '1, b2a_load_n = '1, b2a_drv_n = '1;
  logic [DW-1:0] a_out, a_oe, b_out, b_oe;
  logic [NB-1:0] clash;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_xcvr #(.BYTE_W(BW), .NUM_BYTES(NB)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .a2b_sel_n(a2b_sel_n), .a2b_load_n(a2b_load_n), .a2b_drv_n(a2b_drv_n),
    .b2a_sel_n(b2a_sel_n), .b2a_load_n(b2a_load_n), .b2a_drv_n(b2a_drv_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe), .clash(clash)
  );

  typedef struct packed {
    logic [15:0] a, b;
    logic [1:0]  ab_s, ab_l, ab_d, ba_s, ba_l, ba_d;
    logic [15:0] x_aout, x_aoe, x_bout, x_boe;
    logic [1:0]  x_clash;
    logic [7:0]  req;
  } row_t;

  // Control bit 1 = byte 1, bit 0 = byte 0; all controls active low.
  localparam int NROWS = 9;
  localparam row_t ROWS [NROWS] = '{
    // R2/R4: forward load, both bytes driving
    '{16'h1234, 16'h0000, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 16'h0000, 16'h0000, 16'h1234, 16'hFFFF, 2'b00, 8'd2},
    // R3: load high, store holds while a_in changes
    '{16'hABCD, 16'h0000, 2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 16'h0000, 16'h0000, 16'h1234, 16'hFFFF, 2'b00, 8'd3},
    // R9: select high, load/drive low ignored
    '{16'h5A5A, 16'h0000, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11, 16'h0000, 16'h0000, 16'h1234, 16'h0000, 2'b00, 8'd9},
    // R6: only byte 0 active
    '{16'hFFFF, 16'h0000, 2'b10, 2'b10, 2'b10, 2'b11, 2'b11, 2'b11, 16'h0000, 16'h0000, 16'h12FF, 16'h00FF, 2'b00, 8'd6},
    // R5: reverse load and drive
    '{16'h0000, 16'hC3A5, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 16'hC3A5, 16'hFFFF, 16'h12FF, 16'h0000, 2'b00, 8'd5},
    // R7: contention on byte 1 only
    '{16'h0000, 16'h0000, 2'b00, 2'b11, 2'b01, 2'b00, 2'b11, 2'b00, 16'hC3A5, 16'hFFFF, 16'h12FF, 16'hFF00, 2'b10, 8'd7},
    // R7: contention on both bytes
    '{16'h0000, 16'h0000, 2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'hC3A5, 16'hFFFF, 16'h12FF, 16'hFFFF, 2'b11, 8'd7},
    // R8: stores load with outputs disabled; data still visible
    '{16'h0F0F, 16'hF0F0, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 16'hF0F0, 16'h0000, 16'h0F0F, 16'h0000, 2'b00, 8'd8},
    // R9: reverse select high, load/drive low ignored
    '{16'h0000, 16'h1111, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 16'hF0F0, 16'h0000, 16'h0F0F, 16'h0000, 2'b00, 8'd9}
  };

  task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input int req, input logic [15:0] xa, input logic [15:0] xao,
                           input logic [15:0] xb, input logic [15:0] xbo, input logic [1:0] xc);
    check(req, "a_out", a_out, xa);
    check(req, "a_oe",  a_oe,  xao);
    check(req, "b_out", b_out, xb);
    check(req, "b_oe",  b_oe,  xbo);
    check(req, "clash", {14'd0, clash}, {14'd0, xc});
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    step();
    // R1: reset clears everything
    check_all(1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 2'b00);
    rst = 1'b0;

    for (int k = 0; k < NROWS; k++) begin
      a_in = ROWS[k].a;  b_in = ROWS[k].b;
      a2b_sel_n = ROWS[k].ab_s; a2b_load_n = ROWS[k].ab_l; a2b_drv_n = ROWS[k].ab_d;
      b2a_sel_n = ROWS[k].ba_s; b2a_load_n = ROWS[k].ba_l; b2a_drv_n = ROWS[k].ba_d;
      step();
      check_all(int'(ROWS[k].req), ROWS[k].x_aout, ROWS[k].x_aoe,
                ROWS[k].x_bout, ROWS[k].x_boe, ROWS[k].x_clash);
    end

    // R6: byte 1 reverse load while byte 0 reverse holds
    a2b_sel_n = 2'b11; a2b_load_n = 2'b11; a2b_drv_n = 2'b11;
    b_in = 16'h7788; b2a_sel_n = 2'b01; b2a_load_n = 2'b01; b2a_drv_n = 2'b01;
    step();
    check_all(6, 16'h77F0, 16'hFF00, 16'h0F0F, 16'h0000, 2'b00);

    // R1: mid-run reset with everything requested active
    a2b_sel_n = 2'b00; a2b_load_n = 2'b11; a2b_drv_n = 2'b00;
    b2a_sel_n = 2'b00; b2a_load_n = 2'b11; b2a_drv_n = 2'b00;
    rst = 1'b1;
    step();
    check_all(1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 2'b00);
    rst = 1'b0;
    step();
    // R7: contention on both bytes after reset, stores still zero (R3)
    check_all(7, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 2'b11);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule